// File: doc/BRIEF.md
# Logical Right Shift Execution Unit with Condition Flags

This block executes a 32-bit logical right shift for a processor pipeline. A decoded operation arrives with the value to shift, a shift count, the register indices involved, an operand-form code and the current saturation flag. One clock later the unit presents the shifted value, the register index that should receive it, a write enable, and a new five-bit condition-flag vector.

The shift count comes from one of two places. In the register forms it is the low five bits of a register value supplied by the pipeline. In the immediate form it is a five-bit field taken from the instruction. The two-register and immediate forms send the result back to the register that held the shifted value. The three-register form sends it to a separate destination index. The fourth form code is reserved and never asserts the write enable.

The flag vector is ordered {SAT, CY, OV, S, Z}, with SAT at bit 4 and Z at bit 0. The unit computes CY, S and Z, always clears OV, and returns SAT exactly as it arrived.

Top module: `lsr_exec_unit`

## Requirements
- R1: The result equals the source value shifted right by the selected count n (0 to 31), with zeros filling the vacated upper bits.
- R2: In form codes 0 (two-register) and 2 (three-register), n is the low five bits of `in_amt_reg`. Bits 31..5 of `in_amt_reg` have no effect.
- R3: In form code 1 (immediate), n is `in_imm`. `in_amt_reg` has no effect.
- R4: Form codes 0 and 1 set `out_dst` to `in_src_idx`. Form code 2 sets `out_dst` to `in_dst_idx`. All three assert `out_wr_en`.
- R5: Form code 3 is reserved and leaves `out_wr_en` low.
- R6: CY (`out_flags[3]`) equals bit n-1 of the source when n is nonzero, and is 0 when n is 0.
- R7: OV (`out_flags[2]`) is always 0 in a valid result.
- R8: S (`out_flags[1]`) equals bit 31 of the result. Z (`out_flags[0]`) is 1 exactly when the result is zero.
- R9: SAT (`out_flags[4]`) equals the `in_sat` that arrived with the operation.
- R10: `out_valid` is high in the cycle after `in_valid` was high and low otherwise. Result, destination, write enable and flags change only when an operation is accepted. Back-to-back operations each produce their own result.
- R11: During reset, `out_valid`, `out_wr_en`, `out_result`, `out_dst` and `out_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_form | input | 2 | Operand form: 0 two-register, 1 immediate, 2 three-register, 3 reserved |
| in_src | input | 32 | Value to be shifted |
| in_amt_reg | input | 32 | Register value supplying the count in register forms |
| in_imm | input | 5 | Immediate count field |
| in_src_idx | input | 5 | Index of the register holding the shifted value |
| in_dst_idx | input | 5 | Separate destination index for the three-register form |
| in_sat | input | 1 | Current saturation flag |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | 32 | Shifted value |
| out_dst | output | 5 | Destination register index |
| out_wr_en | output | 1 | Register write request |
| out_flags | output | 5 | {SAT, CY, OV, S, Z} |

## Verification
Two flag outcomes can occur in the same cycle: a set carry together with a zero result. This happens when the only set source bit is the last one shifted out. The bench provokes it by shifting 1 right by 1, and by shifting 0x8000_0000 right by 31 through an immediate count. In the first case it expects CY=1 and Z=1 together. In the second it expects CY=0 alongside a result of 1, so a carry picked from the wrong bit position is caught. A second overlap is back-to-back issue, where a new operation is captured while the previous result is still on the outputs. The bench judges it by checking each result in its own cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned IDX_W  = 5;

  typedef enum logic [1:0] {
    FORM_RR  = 2'd0,
    FORM_IMM = 2'd1,
    FORM_RRR = 2'd2,
    FORM_RSV = 2'd3
  } lsr_form_e;

  typedef struct packed {
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } lsr_flags_t;

endpackage

// File: rtl/lsr_amount_sel.sv
module lsr_amount_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [1:0]        form,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [AMT_W-1:0]  imm,
  output logic [AMT_W-1:0]  amt
);
  import lsr_pkg::*;

  // Only the low bits of the count register are meaningful.
  logic unused_amt_hi;
  assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

  always_comb begin
    if (lsr_form_e'(form) == FORM_IMM) amt = imm;
    else                               amt = amt_reg[AMT_W-1:0];
  end
endmodule

// File: rtl/lsr_barrel.sv
module lsr_barrel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] result,
  output logic              carry
);
  localparam int unsigned EXT_W = DATA_W + 1;

  // A guard bit below the LSB collects the last bit shifted out.
  // With a zero count the guard stays 0.
  logic [EXT_W-1:0] stage [AMT_W+1];

  assign stage[0] = {src, 1'b0};

  for (genvar g = 0; g < AMT_W; g++) begin : g_stage
    localparam int unsigned STEP = 1 << g;
    always_comb begin
      if (amt[g]) stage[g+1] = {{STEP{1'b0}}, stage[g][EXT_W-1:STEP]};
      else        stage[g+1] = stage[g];
    end
  end

  assign result = stage[AMT_W][EXT_W-1:1];
  assign carry  = stage[AMT_W][0];
endmodule

// File: rtl/lsr_flag_gen.sv
module lsr_flag_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]  result,
  input  logic               carry,
  input  logic               sat_in,
  output lsr_pkg::lsr_flags_t flags
);
  always_comb begin
    flags.sat = sat_in;
    flags.cy  = carry;
    flags.ov  = 1'b0;
    flags.s   = result[DATA_W-1];
    flags.z   = (result == '0);
  end
endmodule

// File: rtl/lsr_dest_sel.sv
module lsr_dest_sel #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       form,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  output logic [IDX_W-1:0] dst,
  output logic             wr_en
);
  import lsr_pkg::*;

  always_comb begin
    unique case (lsr_form_e'(form))
      FORM_RR, FORM_IMM: begin dst = src_idx; wr_en = 1'b1; end
      FORM_RRR:          begin dst = dst_idx; wr_en = 1'b1; end
      default:           begin dst = src_idx; wr_en = 1'b0; end
    endcase
  end
endmodule

// File: rtl/lsr_exec_unit.sv
module lsr_exec_unit
  import lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_form,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_amt_reg,
  input  logic [AMT_W-1:0]  in_imm,
  input  logic [IDX_W-1:0]  in_src_idx,
  input  logic [IDX_W-1:0]  in_dst_idx,
  input  logic              in_sat,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dst,
  output logic              out_wr_en,
  output logic [4:0]        out_flags
);

  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;
  logic              carry;
  lsr_flags_t        flags_d;
  logic [IDX_W-1:0]  dst_d;
  logic              wr_en_d;

  lsr_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .form    (in_form),
    .amt_reg (in_amt_reg),
    .imm     (in_imm),
    .amt     (amt)
  );

  lsr_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .src    (in_src),
    .amt    (amt),
    .result (shifted),
    .carry  (carry)
  );

  lsr_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .result (shifted),
    .carry  (carry),
    .sat_in (in_sat),
    .flags  (flags_d)
  );

  lsr_dest_sel #(.IDX_W(IDX_W)) u_dest (
    .form    (in_form),
    .src_idx (in_src_idx),
    .dst_idx (in_dst_idx),
    .dst     (dst_d),
    .wr_en   (wr_en_d)
  );

  // Next-state for the output stage; data registers load only on accept.
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic [IDX_W-1:0]  dst_q, dst_nx;
  logic              wr_en_q, wr_en_nx;
  lsr_flags_t        flags_q, flags_nx;
  logic              load_en;

  always_comb begin
    load_en  = in_valid;
    valid_d  = in_valid;
    result_d = result_q;
    dst_nx   = dst_q;
    wr_en_nx = wr_en_q;
    flags_nx = flags_q;
    if (load_en) begin
      result_d = shifted;
      dst_nx   = dst_d;
      wr_en_nx = wr_en_d;
      flags_nx = flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      dst_q    <= '0;
      wr_en_q  <= 1'b0;
      flags_q  <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
      dst_q    <= dst_nx;
      wr_en_q  <= wr_en_nx;
      flags_q  <= flags_nx;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_dst    = dst_q;
  assign out_wr_en  = wr_en_q;
  assign out_flags  = flags_q;

endmodule

// File: rtl/lsr_exec_unit_chk.sv
module lsr_exec_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_form,
  input logic [4:0]  in_imm,
  input logic [4:0]  in_dst_idx,
  input logic [4:0]  in_src_idx,
  input logic        in_sat,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic [4:0]  out_dst,
  input logic        out_wr_en,
  input logic [4:0]  out_flags
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_flags));

  a_r7_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[2]);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[0] == (out_result == 32'd0)));

  a_r8_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[1] == out_result[31]));

  a_r9_sat_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_flags[4] == $past(in_sat)));

  a_r5_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_form == 2'd3) |=> !out_wr_en);

  a_r4_third_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_form == 2'd2) |=> (out_wr_en && out_dst == $past(in_dst_idx)));

  a_r4_back_to_src: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_form == 2'd0 || in_form == 2'd1)) |=> (out_wr_en && out_dst == $past(in_src_idx)));

  a_r6_zero_count_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_form == 2'd1 && in_imm == 5'd0) |=> !out_flags[3]);

endmodule

bind lsr_exec_unit lsr_exec_unit_chk u_chk (.*);

// File: tb/lsr_exec_unit_tb.sv
module lsr_exec_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_form;
  logic [31:0] in_src;
  logic [31:0] in_amt_reg;
  logic [4:0]  in_imm;
  logic [4:0]  in_src_idx;
  logic [4:0]  in_dst_idx;
  logic        in_sat;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_dst;
  logic        out_wr_en;
  logic [4:0]  out_flags;

  int n_checks = 0;
  int n_fails  = 0;

  lsr_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
    .in_src(in_src), .in_amt_reg(in_amt_reg), .in_imm(in_imm),
    .in_src_idx(in_src_idx), .in_dst_idx(in_dst_idx), .in_sat(in_sat),
    .out_valid(out_valid), .out_result(out_result), .out_dst(out_dst),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Drive one operation, then sample its outputs at the following falling edge.
  task automatic drive(input logic [1:0] form, input logic [31:0] src,
                       input logic [31:0] amtr, input logic [4:0] imm,
                       input logic [4:0] sidx, input logic [4:0] didx, input logic sat);
    @(negedge clk);
    in_valid = 1'b1; in_form = form; in_src = src; in_amt_reg = amtr;
    in_imm = imm; in_src_idx = sidx; in_dst_idx = didx; in_sat = sat;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [4:0] exp_flags(input logic [31:0] src, input int n, input logic sat);
    logic [31:0] r;
    logic cy;
    r  = src >> n;
    cy = (n == 0) ? 1'b0 : src[n-1];
    return {sat, cy, 1'b0, r[31], (r == 32'd0)};
  endfunction

  task automatic op_check(input string tag, input logic [1:0] form, input logic [31:0] src,
                          input logic [31:0] amtr, input logic [4:0] imm,
                          input logic [4:0] sidx, input logic [4:0] didx, input logic sat);
    int n;
    logic [4:0] edst;
    n    = (form == 2'd1) ? int'(imm) : int'(amtr[4:0]);
    edst = (form == 2'd2) ? didx : sidx;
    drive(form, src, amtr, imm, sidx, didx, sat);
    check({tag, " valid"},  32'(out_valid), 32'd1);
    check({tag, " result"}, out_result, src >> n);
    check({tag, " flags"},  32'(out_flags), 32'(exp_flags(src, n, sat)));
    if (form != 2'd3) check({tag, " dst"}, 32'(out_dst), 32'(edst));
    check({tag, " wr_en"}, 32'(out_wr_en), (form == 2'd3) ? 32'd0 : 32'd1);
  endtask

  task automatic t_reset;
    check("R11 valid",  32'(out_valid), 32'd0);
    check("R11 wr_en",  32'(out_wr_en), 32'd0);
    check("R11 result", out_result, 32'd0);
    check("R11 dst",    32'(out_dst), 32'd0);
    check("R11 flags",  32'(out_flags), 32'd0);
  endtask

  task automatic t_reg_form;
    op_check("R1 rr shift4",        2'd0, 32'hF0F0_1234, 32'd4, 5'd0, 5'd3, 5'd9, 1'b0);
    op_check("R2 rr upper ignored", 2'd0, 32'hDEAD_BEEF, 32'hFFFF_FFE8, 5'd3, 5'd7, 5'd1, 1'b0);
    op_check("R1 rr shift16",       2'd0, 32'h8765_4321, 32'd16, 5'd0, 5'd2, 5'd2, 1'b1);
  endtask

  task automatic t_imm_form;
    op_check("R3 imm reg ignored", 2'd1, 32'hA5A5_A5A5, 32'h0000_001F, 5'd8, 5'd11, 5'd20, 1'b0);
    op_check("R3 imm 31",          2'd1, 32'hFFFF_FFFF, 32'd0, 5'd31, 5'd4, 5'd5, 1'b0);
  endtask

  task automatic t_three_reg;
    op_check("R4 rrr dst", 2'd2, 32'h0000_FF00, 32'd8, 5'd0, 5'd6, 5'd27, 1'b0);
    op_check("R4 rr dst",  2'd0, 32'h0000_FF00, 32'd8, 5'd0, 5'd6, 5'd27, 1'b0);
  endtask

  task automatic t_reserved;
    op_check("R5 reserved", 2'd3, 32'h1234_5678, 32'd2, 5'd0, 5'd1, 5'd2, 1'b0);
  endtask

  task automatic t_carry;
    op_check("R6 zero count",        2'd0, 32'hFFFF_FFFF, 32'h0000_0020, 5'd0, 5'd1, 5'd1, 1'b0);
    op_check("R6 imm zero",          2'd1, 32'h8000_0001, 32'd5, 5'd0, 5'd1, 5'd1, 1'b0);
    op_check("R6 bit n-1 set",       2'd0, 32'h0000_0010, 32'd5, 5'd0, 5'd1, 5'd1, 1'b0);
    op_check("R6 bit n-1 clear",     2'd0, 32'h0000_0010, 32'd4, 5'd0, 5'd1, 5'd1, 1'b0);
    op_check("R6 R8 carry and zero", 2'd0, 32'h0000_0001, 32'd1, 5'd0, 5'd1, 5'd1, 1'b0);
    op_check("R6 max shift",         2'd1, 32'h8000_0000, 32'd0, 5'd31, 5'd1, 5'd1, 1'b0);
    check("R6 max shift cy", 32'(out_flags[3]), 32'd0);
  endtask

  task automatic t_flags;
    op_check("R8 sign at zero shift", 2'd0, 32'h8000_0000, 32'd0, 5'd0, 5'd1, 5'd1, 1'b0);
    check("R8 sign bit", 32'(out_flags[1]), 32'd1);
    op_check("R8 zero src", 2'd2, 32'd0, 32'd3, 5'd0, 5'd1, 5'd1, 1'b0);
    check("R8 zero bit", 32'(out_flags[0]), 32'd1);
    check("R7 ov clear", 32'(out_flags[2]), 32'd0);
  endtask

  task automatic t_sat;
    op_check("R9 sat set",   2'd1, 32'h0000_00F0, 32'd0, 5'd4, 5'd1, 5'd1, 1'b1);
    check("R9 sat bit", 32'(out_flags[4]), 32'd1);
    op_check("R9 sat clear", 2'd1, 32'h0000_00F0, 32'd0, 5'd4, 5'd1, 5'd1, 1'b0);
    check("R9 sat bit low", 32'(out_flags[4]), 32'd0);
  endtask

  task automatic t_timing;
    logic [31:0] held;
    op_check("R10 first", 2'd0, 32'hCAFE_0000, 32'd12, 5'd0, 5'd8, 5'd0, 1'b0);
    held = out_result;
    // Inputs change while idle: outputs must not move.
    in_src = 32'h1111_1111; in_amt_reg = 32'd1; in_form = 2'd2; in_sat = 1'b1;
    @(negedge clk);
    check("R10 idle valid low", 32'(out_valid), 32'd0);
    check("R10 idle result held", out_result, held);
    check("R10 idle wr_en held", 32'(out_wr_en), 32'd1);
    check("R10 idle dst held", 32'(out_dst), 32'd8);
    // Back-to-back issue.
    in_valid = 1'b1; in_form = 2'd0; in_src = 32'h0000_0F00; in_amt_reg = 32'd8;
    in_src_idx = 5'd12; in_sat = 1'b0;
    @(negedge clk);
    in_form = 2'd2; in_src = 32'hFFFF_0000; in_amt_reg = 32'd16; in_dst_idx = 5'd30;
    check("R10 b2b first result", out_result, 32'h0000_000F);
    check("R10 b2b first dst", 32'(out_dst), 32'd12);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 b2b second result", out_result, 32'h0000_FFFF);
    check("R10 b2b second dst", 32'(out_dst), 32'd30);
    check("R10 b2b second valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R10 b2b drain", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #80000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_form = 2'd0; in_src = '0; in_amt_reg = '0;
    in_imm = '0; in_src_idx = '0; in_dst_idx = '0; in_sat = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reg_form;
    t_imm_form;
    t_three_reg;
    t_reserved;
    t_carry;
    t_flags;
    t_sat;
    t_timing;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule